// File: doc/BRIEF.md
# Four-Mode Addressable Bit Latch

This block keeps a small bank of single-bit storage cells. Each cell is reached through a shared address and written one bit at a time from a serial data input. The eight cells drive eight parallel outputs. Two control pins select the mode. The first is an active-low write enable and the second is an active-high clear. Together they give four modes. Addressable latch mode writes the selected bit and leaves the others as they are. Memory mode freezes every bit. Demultiplexer mode steers the data bit onto the selected output and drives all other outputs low. Clear mode forces every output to zero.

Every decision is taken on the rising clock edge, and the outputs are registered. A clock edge therefore does the work that the open phase of a transparent latch would do. The parameter `DUAL_BANK` changes the organisation from one 8-bit bank with a 3-bit address to two 4-bit banks with a 2-bit address. Both banks share the address, the enable and the clear, and each bank has its own data bit. The address may only change in more than one bit while the block is in memory mode, so an address monitor flags any such change made during addressable latch mode. A synchronous reset, separate from the clear pin, sets all cells to zero.

Top module: `bitlatch_top`

## Requirements
- R1: While `rst` is high at a rising edge, all `q_out` bits and `addr_err` are 0 after that edge, whatever the other inputs are.
- R2: With `en_n`=0 and `clr`=0 (addressable latch mode), the bit selected by `addr` takes the value of its data input after the edge, and every other bit keeps its value.
- R3: With `en_n`=1 and `clr`=0 (memory mode), all bits keep their values after the edge, whatever `addr` and `data_in` are.
- R4: With `en_n`=0 and `clr`=1 (demultiplexer mode), after the edge the selected bit equals its data input and every other bit is 0.
- R5: With `en_n`=1 and `clr`=1 (clear mode), all bits are 0 after the edge.
- R6: Bits forced low in demultiplexer mode stay 0 in later memory-mode cycles. Their earlier values do not come back.
- R7: With `DUAL_BANK`=0, address value k selects `q_out[k]` and `data_in[0]` feeds it. With `DUAL_BANK`=1, address value k selects `q_out[k]`, fed by `data_in[0]`, and `q_out[4+k]`, fed by `data_in[1]`.
- R8: `addr_err` is 1 for the one cycle after an edge only if that edge was in addressable latch mode and `addr` differed in two or more bits from its value at the previous edge. The first edge after reset never flags. A multi-bit change in any other mode never flags.
- R9: A flagged latch-mode cycle still writes the data bit at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low write enable |
| clr | input | 1 | Active-high clear, shared by all bits |
| addr | input | ADDR_W (3, or 2 when dual) | Bit select within a bank |
| data_in | input | NUM_BANKS (1, or 2 when dual) | Serial data bit, one per bank |
| q_out | output | OUT_BITS (8) | Registered parallel outputs |
| addr_err | output | 1 | Multi-bit address change seen during latch mode |

## Verification
The write path and the address monitor can both act in the same cycle. When the address jumps in two or more bits during addressable latch mode, the block stores the data bit at the new address and also raises the error flag. The bench provokes this by latching at address 0 and then latching at address 3 with data 1. After the second edge it expects bit 3 set, bit 0 kept and `addr_err` high. A second overlap occurs when reset and a latch write arrive together, and there reset must win. The bench also makes a multi-bit jump in memory mode and follows it with a latch cycle at the same address, and then it expects no flag.

// File: rtl/bitlatch_pkg.sv
package bitlatch_pkg;

  // Mode code is {clr, en_n}
  typedef enum logic [1:0] {
    MODE_LATCH = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_DEMUX = 2'b10,
    MODE_CLEAR = 2'b11
  } latch_mode_e;

  // True when two address words differ in two or more bit positions
  function automatic logic multi_bit_change(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] diff;
    int unsigned cnt;
    diff = a ^ b;
    cnt = 0;
    for (int i = 0; i < 8; i++) cnt += diff[i] ? 1 : 0;
    return cnt > 1;
  endfunction

endpackage

// File: rtl/bitlatch_mode_decode.sv
module bitlatch_mode_decode
  import bitlatch_pkg::*;
(
  input  logic        en_n,
  input  logic        clr,
  output latch_mode_e mode
);
  always_comb begin
    unique case ({clr, en_n})
      2'b00:   mode = MODE_LATCH;
      2'b01:   mode = MODE_HOLD;
      2'b10:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/bitlatch_bank.sv
module bitlatch_bank
  import bitlatch_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  latch_mode_e       mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [WIDTH-1:0]  q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic sel;
    logic cell_q;

    assign sel = (addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q <= 1'b0;
      end else begin
        unique case (mode)
          MODE_LATCH: if (sel) cell_q <= din;
          MODE_HOLD:  cell_q <= cell_q;
          MODE_DEMUX: cell_q <= sel & din;
          default:    cell_q <= 1'b0;
        endcase
      end
    end

    assign q[i] = cell_q;
  end
endmodule

// File: rtl/bitlatch_addr_monitor.sv
module bitlatch_addr_monitor
  import bitlatch_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  latch_mode_e       mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_err
);
  logic [ADDR_W-1:0] prev_addr;
  logic              prev_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_addr <= '0;
      prev_ok   <= 1'b0;
      addr_err  <= 1'b0;
    end else begin
      prev_addr <= addr;
      prev_ok   <= 1'b1;
      addr_err  <= prev_ok && (mode == MODE_LATCH) &&
                   multi_bit_change(8'(addr), 8'(prev_addr));
    end
  end
endmodule

// File: rtl/bitlatch_top.sv
module bitlatch_top
  import bitlatch_pkg::*;
#(
  parameter bit DUAL_BANK = 1'b0,
  parameter int OUT_BITS  = 8,
  parameter int NUM_BANKS = DUAL_BANK ? 2 : 1,
  parameter int BANK_W    = OUT_BITS / NUM_BANKS,
  parameter int ADDR_W    = $clog2(BANK_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_n,
  input  logic                 clr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] data_in,
  output logic [OUT_BITS-1:0]  q_out,
  output logic                 addr_err
);
  latch_mode_e mode;

  bitlatch_mode_decode u_dec (
    .en_n (en_n),
    .clr  (clr),
    .mode (mode)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bitlatch_bank #(
      .WIDTH  (BANK_W),
      .ADDR_W (ADDR_W)
    ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .addr (addr),
      .din  (data_in[b]),
      .q    (q_out[b*BANK_W +: BANK_W])
    );
  end

  bitlatch_addr_monitor #(
    .ADDR_W (ADDR_W)
  ) u_mon (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .addr     (addr),
    .addr_err (addr_err)
  );
endmodule

// File: rtl/bitlatch_checker.sv
module bitlatch_checker #(
  parameter int OUT_BITS  = 8,
  parameter int NUM_BANKS = 1,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en_n,
  input logic                 clr,
  input logic [ADDR_W-1:0]    addr,
  input logic [NUM_BANKS-1:0] data_in,
  input logic [OUT_BITS-1:0]  q_out,
  input logic                 addr_err
);
  logic armed = 1'b0;
  logic [OUT_BITS-1:0] sel_mask;

  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  always_comb begin
    for (int i = 0; i < OUT_BITS; i++)
      sel_mask[i] = (32'(addr) == (i % BANK_W));
  end

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(rst)) |-> (q_out == '0 && !addr_err));

  p_latch_others_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && !$past(en_n) && !$past(clr))
      |-> (((q_out ^ $past(q_out)) & ~$past(sel_mask)) == '0));

  p_memory_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(en_n) && !$past(clr)) |-> $stable(q_out));

  p_demux_low_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && !$past(en_n) && $past(clr))
      |-> ((q_out & ~$past(sel_mask)) == '0));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(en_n) && $past(clr)) |-> (q_out == '0));

  p_err_latch_only_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && addr_err) |-> (!$past(en_n) && !$past(clr)));
endmodule

bind bitlatch_top bitlatch_checker #(
  .OUT_BITS  (OUT_BITS),
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en_n     (en_n),
  .clr      (clr),
  .addr     (addr),
  .data_in  (data_in),
  .q_out    (q_out),
  .addr_err (addr_err)
);

// File: tb/tb_bitlatch_top.sv
module tb_bitlatch_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_n = 1'b1, clr = 1'b0, data_in = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] q_out;
  logic       addr_err;

  logic       d_en_n = 1'b1, d_clr = 1'b0;
  logic [1:0] d_addr = '0, d_data = '0;
  logic [7:0] d_q;
  logic       d_err;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_q = '0;
  logic [2:0] m_prev = '0;
  logic       m_prev_ok = 1'b0;
  logic       m_err = 1'b0;

  always #4 clk = ~clk;

  bitlatch_top dut (
    .clk(clk), .rst(rst), .en_n(en_n), .clr(clr),
    .addr(addr), .data_in(data_in), .q_out(q_out), .addr_err(addr_err)
  );

  bitlatch_top #(.DUAL_BANK(1'b1)) dut_dual (
    .clk(clk), .rst(rst), .en_n(d_en_n), .clr(d_clr),
    .addr(d_addr), .data_in(d_data), .q_out(d_q), .addr_err(d_err)
  );

  // Vector: {en_n, clr, addr[2:0], data}
  localparam int VN = 20;
  localparam logic [5:0] VEC [VN] = '{
    6'b00_000_1, 6'b00_001_1, 6'b00_010_0, 6'b00_011_1, 6'b10_110_1,
    6'b00_111_1, 6'b00_101_1, 6'b10_000_0, 6'b01_010_1, 6'b01_110_1,
    6'b01_110_0, 6'b00_100_1, 6'b00_100_0, 6'b00_001_1, 6'b11_011_1,
    6'b00_110_1, 6'b00_010_1, 6'b10_101_0, 6'b00_011_1, 6'b11_000_0
  };

  function automatic string mode_tag(input logic e, input logic c);
    if (!e && !c) return "R2";
    if (e && !c)  return "R3";
    if (!e && c)  return "R4";
    return "R5";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic r, input logic e, input logic c,
                       input logic [2:0] a, input logic d);
    int cnt;
    if (r) begin
      m_q = '0; m_err = 1'b0; m_prev = '0; m_prev_ok = 1'b0;
    end else begin
      cnt = $countones(a ^ m_prev);
      m_err = m_prev_ok && !e && !c && (cnt > 1);
      case ({c, e})
        2'b00: m_q[a] = d;
        2'b01: ;
        2'b10: begin m_q = '0; m_q[a] = d; end
        default: m_q = '0;
      endcase
      m_prev = a; m_prev_ok = 1'b1;
    end
  endtask

  task automatic step(input logic r, input logic e, input logic c,
                      input logic [2:0] a, input logic d, input string tag);
    @(negedge clk);
    rst = r; en_n = e; clr = c; addr = a; data_in = d;
    @(posedge clk);
    model(r, e, c, a, d);
    #2;
    chk(tag, q_out, m_q);
    chk({tag, " R8 flag"}, {7'b0, addr_err}, {7'b0, m_err});
  endtask

  task automatic dstep(input logic e, input logic c, input logic [1:0] a,
                       input logic [1:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk);
    d_en_n = e; d_clr = c; d_addr = a; d_data = d;
    @(posedge clk);
    #2;
    chk(tag, d_q, exp);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    step(1, 1, 0, 0, 0, "R1 reset");
    step(1, 1, 0, 0, 0, "R1 reset");
    chk("R1 dual reset", d_q, 8'h00);

    // Table walk over all modes
    for (int i = 0; i < VN; i++)
      step(0, VEC[i][5], VEC[i][4], VEC[i][3:1], VEC[i][0], mode_tag(VEC[i][5], VEC[i][4]));

    // R1: reset wins over a latch write in the same cycle
    step(0, 0, 0, 3'd2, 1, "R2 setup");
    step(1, 0, 0, 3'd4, 1, "R1 reset priority");
    chk("R1 all low", q_out, 8'h00);

    // R6: demux then memory keeps forced-low bits at 0
    for (int k = 0; k < 8; k++) step(0, 0, 0, 3'(k), 1, "R2 fill");
    chk("R2 filled", q_out, 8'hFF);
    step(0, 0, 1, 3'd5, 1, "R4 demux");
    chk("R4 one-hot", q_out, 8'h20);
    step(0, 1, 0, 3'd2, 1, "R6 hold after demux");
    chk("R6 no restore", q_out, 8'h20);
    step(0, 0, 0, 3'd5, 0, "R6 latch after demux");
    chk("R6 cleared", q_out, 8'h00);

    // R8: multi-bit change in memory mode does not flag
    step(0, 0, 0, 3'd0, 1, "R2 at 0");
    step(0, 1, 0, 3'd7, 0, "R3 jump in memory");
    chk("R8 memory jump no flag", {7'b0, addr_err}, 8'h00);
    step(0, 0, 0, 3'd7, 1, "R2 at 7");
    chk("R8 settled addr no flag", {7'b0, addr_err}, 8'h00);
    chk("R2 bits 0 and 7", q_out, 8'h81);

    // R9: flagged write in the same cycle as the latch
    step(0, 0, 0, 3'd0, 0, "R2 at 0");
    step(0, 0, 0, 3'd3, 1, "R9 flagged write");
    chk("R9 write done", q_out, 8'h88);
    chk("R9 flag high", {7'b0, addr_err}, 8'h01);

    // R7: dual-bank mapping
    dstep(0, 0, 2'd1, 2'b10, 8'h20, "R7 dual latch a1");
    dstep(0, 0, 2'd3, 2'b11, 8'hA8, "R7 dual latch a3");
    dstep(1, 0, 2'd0, 2'b11, 8'hA8, "R7 dual hold");
    dstep(0, 1, 2'd2, 2'b01, 8'h04, "R7 dual demux");
    dstep(1, 1, 2'd2, 2'b11, 8'h00, "R7 dual clear");

    summary();
    $finish;
  end
endmodule